// File: doc/BRIEF.md
# Power-On Reset Filter and Stretcher

This block turns a raw, asynchronous power-good level into a clean, active-low root reset for the whole chip. It runs on a slow clock that never stops, typically in the kHz range. The power-good input is sampled by a chain of flip-flops that acts both as a synchronizer and as a debounce filter. A release counter then runs for a fixed number of slow-clock cycles, and the root reset deasserts only after that stretch has completed.

When power-good falls, the filter chain, the counter and the output register are all cleared asynchronously, so the root reset asserts at once, without waiting for a clock. An optional active-low reset-pad level enters the filter chain synchronously, beside power-good. Any zero that the pad places in the filter clears the counter and re-asserts the reset. The pad then holds the reset for as long as it stays low, and a full stretch follows once it returns high.

All control here is level-based. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `por_reset_gen`

## Requirements
- R1: While `pwr_good_i` is 0, `rst_no` is 0. A falling `pwr_good_i` drives `rst_no` to 0 without waiting for a clock edge.
- R2: Let S be `STAGES` and T be `STRETCH`. After `pwr_good_i` rises with `pad_rst_ni` held at 1, `rst_no` stays 0 through rising edge S+T and reads 1 after rising edge S+T+1.
- R3: When `pad_rst_ni` is sampled at 0 on rising edge p, `rst_no` reads 0 after edge p+1 at the latest. The pad is only used when `USE_PAD` is 1.
- R4: When p is the last rising edge that sampled `pad_rst_ni` at 0, `rst_no` stays 0 through edge p+S+T and reads 1 after edge p+S+T+1.
- R5: A pad pulse of one or more cycles during the stretch restarts the count from zero. The full S+T+1 edge delay of R4 then applies again.
- R6: Once released, `rst_no` stays 1 for as long as power-good and the pad stay high. The release counter saturates at T and never wraps.
- R7: `rst_no` rises only on an edge whose previous cycle had the counter at T and every filter stage at 1. When a stage turns 0 in the same cycle that the counter reaches T, the reset is not released.
- R8: When power-good drops in the middle of a cycle after release, `rst_no` goes to 0 immediately. When power-good rises again, the full count of R2 restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Slow, always-running clock |
| pwr_good_i | input | 1 | Raw asynchronous power-good level, 1 = supply good |
| pad_rst_ni | input | 1 | External reset-pad level, active low, sampled through the filter |
| rst_no | output | 1 | Registered, stretched root reset, active low |

## Verification
Two events can land in the same cycle: the release counter reaching its terminal count, and a zero entering the filter chain from the pad. The bench sweeps the start of a pad-low pulse across every edge from power-up to beyond release, and it uses several pulse widths. One of these positions places the pad sample on exactly the edge where the counter saturates. For each edge n the bench predicts the reset with one formula: the reset is released when n minus the last pad-low edge before n is at least S+T+1. It compares that prediction with `rst_no` at mid-cycle. Separate cases drop power-good between edges, both after release and before release.

// File: rtl/por_pkg.sv
package por_pkg;
  localparam int unsigned POR_DEF_STAGES  = 3;
  localparam int unsigned POR_DEF_STRETCH = 32;

  function automatic int unsigned por_cnt_width(input int unsigned term);
    return (term < 2) ? 1 : $clog2(term + 1);
  endfunction
endpackage

// File: rtl/por_sync_filter.sv
module por_sync_filter #(
  parameter int unsigned STAGES = por_pkg::POR_DEF_STAGES
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic din_i,
  output logic all_ones_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) stage_q[0] <= 1'b0;
        else          stage_q[0] <= din_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) stage_q[i] <= 1'b0;
        else          stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign all_ones_o = &stage_q;

  // R3
  zero_in_filter_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !din_i |=> !all_ones_o);
endmodule

// File: rtl/por_stretch_count.sv
module por_stretch_count #(
  parameter int unsigned STRETCH = por_pkg::POR_DEF_STRETCH
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = por_pkg::por_cnt_width(STRETCH);
  localparam logic [CW-1:0] TERM = CW'(STRETCH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)           cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != TERM) cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = (cnt_q == TERM);

  // R6
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (cnt_q == TERM) |=> (cnt_q == TERM) || (cnt_q == '0));
  // R2
  single_step_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + CW'(1)) || (cnt_q == $past(cnt_q)));
  // R5
  restart_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/por_out_reg.sv
module por_out_reg (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic release_i,
  output logic rst_no
);
  logic rst_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) rst_q <= 1'b0;
    else          rst_q <= release_i;
  end

  assign rst_no = rst_q;
endmodule

// File: rtl/por_reset_gen.sv
module por_reset_gen #(
  parameter int unsigned STAGES  = por_pkg::POR_DEF_STAGES,
  parameter int unsigned STRETCH = por_pkg::POR_DEF_STRETCH,
  parameter bit          USE_PAD = 1'b1
) (
  input  logic clk_slow_i,
  input  logic pwr_good_i,
  input  logic pad_rst_ni,
  output logic rst_no
);
  logic filt_in;
  logic all_ones;
  logic cnt_done;

  if (USE_PAD) begin : g_pad
    assign filt_in = pad_rst_ni;
  end else begin : g_nopad
    assign filt_in = 1'b1;
  end

  por_sync_filter #(.STAGES(STAGES)) u_filter (
    .clk_i      (clk_slow_i),
    .arst_ni    (pwr_good_i),
    .din_i      (filt_in),
    .all_ones_o (all_ones)
  );

  por_stretch_count #(.STRETCH(STRETCH)) u_count (
    .clk_i   (clk_slow_i),
    .arst_ni (pwr_good_i),
    .run_i   (all_ones),
    .done_o  (cnt_done)
  );

  por_out_reg u_out (
    .clk_i     (clk_slow_i),
    .arst_ni   (pwr_good_i),
    .release_i (cnt_done & all_ones),
    .rst_no    (rst_no)
  );

  // R7
  release_cause_chk: assert property (@(posedge clk_slow_i) disable iff (!pwr_good_i)
    $rose(rst_no) |-> $past(cnt_done && all_ones));
  // R3
  filter_zero_holds_chk: assert property (@(posedge clk_slow_i) disable iff (!pwr_good_i)
    !all_ones |=> !rst_no);

  // R1
  always_ff @(posedge clk_slow_i) begin
    if (!pwr_good_i) pg_low_chk: assert (!rst_no);
  end
endmodule

// File: tb/tb_por_reset_gen.sv
module tb_por_reset_gen;
  localparam int S = 3;
  localparam int T = 8;

  logic clk = 1'b0;
  logic pwr_good = 1'b0;
  logic pad_n = 1'b1;
  logic rst_n;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  por_reset_gen #(.STAGES(S), .STRETCH(T), .USE_PAD(1'b1)) dut (
    .clk_slow_i (clk),
    .pwr_good_i (pwr_good),
    .pad_rst_ni (pad_n),
    .rst_no     (rst_n)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Power up and run ncyc edges; pad is low on edges [lo_start, lo_start+lo_width).
  task automatic run_case(input int lo_start, input int lo_width, input int ncyc);
    int last_lo = 0;
    @(negedge clk);
    pwr_good = 1'b0;
    pad_n = 1'b1;
    #1 check(rst_n, 1'b0, "R1");
    @(negedge clk);
    pwr_good = 1'b1;
    for (int n = 1; n <= ncyc; n++) begin
      logic exp;
      string tag;
      int nxt;
      pad_n = (lo_width > 0 && n >= lo_start && n < lo_start + lo_width) ? 1'b0 : 1'b1;
      exp = ((n - last_lo) >= S + T + 1);
      nxt = pad_n ? last_lo : n;
      if (lo_width == 0)                 tag = (n > S + T + 1) ? "R6" : "R2";
      else if (lo_start == S + T)        tag = "R7";
      else if (n <= lo_start + lo_width) tag = "R3";
      else if (lo_start < S + T + 1)     tag = "R5";
      else                               tag = "R4";
      @(posedge clk);
      #2 check(rst_n, exp, tag);
      last_lo = nxt;
      @(negedge clk);
    end
  endtask

  initial begin
    #1 check(rst_n, 1'b0, "R1");
    // plain power-up and long hold for saturation
    run_case(0, 0, S + T + 1 + 4 * T);
    // pad pulse sweep over position and width
    for (int w = 1; w <= 3; w++)
      for (int st = 1; st <= S + T + 4; st++)
        run_case(st, w, st + w + S + T + 4);
    // mid-cycle power-good drop after release, then full recount
    run_case(0, 0, S + T + 3);
    @(posedge clk);
    #3 pwr_good = 1'b0;
    #1 check(rst_n, 1'b0, "R8");
    repeat (3) @(posedge clk);
    #2 check(rst_n, 1'b0, "R8");
    @(negedge clk);
    pwr_good = 1'b1;
    for (int n = 1; n <= S + T + 4; n++) begin
      @(posedge clk);
      #2 check(rst_n, (n >= S + T + 1) ? 1'b1 : 1'b0, "R8");
    end
    // drop before release, partial count must not carry over
    @(negedge clk);
    pwr_good = 1'b0;
    #1 check(rst_n, 1'b0, "R8");
    @(negedge clk);
    pwr_good = 1'b1;
    repeat (S + 2) @(posedge clk);
    #3 pwr_good = 1'b0;
    #1 check(rst_n, 1'b0, "R8");
    @(negedge clk);
    pwr_good = 1'b1;
    for (int n = 1; n <= S + T + 2; n++) begin
      @(posedge clk);
      #2 check(rst_n, (n >= S + T + 1) ? 1'b1 : 1'b0, "R8");
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end else if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule